// File: doc/BRIEF.md
# Three-Port Programmable Parallel I/O Interface

This block is a bus-attached parallel I/O peripheral. It has three 8-bit ports, called A, B and C. A processor reaches it through an 8-bit data bus with an active-low select, active-low read and write strobes, and a 2-bit address. Addresses 0, 1 and 2 reach ports A, B and C, and address 3 reaches the control register. Port C is split into two 4-bit halves. The upper half belongs to group A, together with port A. The lower half belongs to group B, together with port B.

The control register takes two kinds of word, told apart by bit 7. A word with bit 7 set is a configuration word. It picks the direction of each port and of each half of port C, and it picks basic or strobed handshake operation for ports A and B. A word with bit 7 clear changes one port C line and leaves every other line alone. In basic mode each port is a plain latch or a plain input. In handshake mode the group's half of port C carries four signals: a strobe or acknowledge input, a buffer-state flag, an interrupt request and an interrupt-enable bit. Pads are modelled as separate in, out and output-enable vectors.

Top module: `pio_three_port`

## Requirements
- R1: After reset every port is an input: all three output-enable vectors read 0. The A and B output latches and the port C latch hold 0, every group is in basic mode, and `rdata` is 0.
- R2: A bus cycle counts only while `csN` is low. While `csN` is high, `rdata` is 0 and writes change no state.
- R3: A control write with bit 7 = 1 is a configuration word. The bits mean: bit 6 = port A handshake, bit 5 = port A input, bit 4 = upper port C input, bit 3 = port B handshake, bit 2 = port B input, bit 1 = lower port C input, and bit 0 is ignored. A direction bit of 1 means input, which gives an output-enable of 0.
- R4: Every configuration write clears the A, B and C output latches and all handshake state to 0.
- R5: A control write with bit 7 = 0 sets port C bit `wdata[3:1]` to `wdata[0]`. Bits 6:4 are ignored. No other port C latch bit changes, and ports A and B are not affected.
- R6: In basic mode an output port drives its latch and reads back that latch. An input port reads its pins live.
- R7: A read of the control address returns 0.
- R8: Handshake input (A uses C4 as strobe and C5 as flag; B uses C0 and C1). While the strobe is low, the port pins are captured and the buffer-full flag goes high. A read of the port returns the captured byte, not the live pins, and clears the flag.
- R9: Handshake output. A write to the port loads the latch and drives the active-low buffer-full flag (C5 or C1) low. A low acknowledge (C4 or C0) while the buffer is full drives the flag high again.
- R10: The interrupt request (C6 for A, C2 for B) equals the group's enable bit (port C latch bit 7 for A, bit 3 for B) ANDed with the event. For input, the event is buffer full. For output, the event is an acknowledge completed since the last write.
- R11: A handshake group's half of port C drives its flag, interrupt and enable bits and leaves the strobe bit undriven. The other half follows its own direction bit.
- R12: A read of port C returns the driven value for each enabled bit and the pin value for each other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low select |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe, acts on each clock edge while low |
| addr | input | 2 | 0 = port A, 1 = port B, 2 = port C, 3 = control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while the read strobe and select are low |
| paIn | input | 8 | Port A pins in |
| paOut | output | 8 | Port A drive value |
| paOe | output | 8 | Port A output-enable |
| pbIn | input | 8 | Port B pins in |
| pbOut | output | 8 | Port B drive value |
| pbOe | output | 8 | Port B output-enable |
| pcIn | input | 8 | Port C pins in |
| pcOut | output | 8 | Port C drive value |
| pcOe | output | 8 | Port C output-enable, per bit |

## Verification
The block has no tunable knobs apart from the package constants: an 8-bit port width, a 4-bit half width and a 2-bit address. The bench builds it with those defaults. Because the half of port C used by each group is picked by a generate index, the defaults reach both halves' handshake wiring: group A input handshake on the upper half and group B output handshake on the lower half. Basic-mode mixes of input and output are also covered, including a split port C.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PIO_W   = 8;
  localparam int HALF_W  = PIO_W / 2;
  localparam int ADDR_W  = 2;
  localparam int SEL_W   = $clog2(PIO_W);

  localparam logic [ADDR_W-1:0] ADR_A    = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_B    = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_C    = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd3;

  // configuration word field positions
  localparam int KIND_BIT  = 7;
  localparam int A_HS_BIT  = 6;
  localparam int A_IN_BIT  = 5;
  localparam int CU_IN_BIT = 4;
  localparam int B_HS_BIT  = 3;
  localparam int B_IN_BIT  = 2;
  localparam int CL_IN_BIT = 1;

  // roles inside one half of port C during handshake
  localparam int STB_OFS  = 0;
  localparam int FLAG_OFS = 1;
  localparam int INTR_OFS = 2;
  localparam int INTE_OFS = 3;

  typedef struct packed {
    logic aHs;
    logic aIn;
    logic cuIn;
    logic bHs;
    logic bIn;
    logic clIn;
  } pioCfg_t;

  localparam pioCfg_t CFG_RESET = '{aHs: 1'b0, aIn: 1'b1, cuIn: 1'b1,
                                    bHs: 1'b0, bIn: 1'b1, clIn: 1'b1};

  typedef struct packed {
    logic              modeWr;
    logic              bitWr;
    logic [SEL_W-1:0]  bitSel;
    logic              bitVal;
    logic              wrA;
    logic              wrB;
    logic              wrC;
    logic              rdA;
    logic              rdB;
    logic              rdEn;
    logic [ADDR_W-1:0] rdAddr;
    logic [PIO_W-1:0]  wdata;
  } pioStrobe_t;
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIO_W-1:0]  wdata,
  output pioStrobe_t        stb,
  output pioCfg_t           cfg
);
  logic wrHit, rdHit, ctrlWr;

  assign wrHit  = !csN && !wrN;
  assign rdHit  = !csN && !rdN;
  assign ctrlWr = wrHit && (addr == ADR_CTRL);

  always_comb begin
    stb        = '0;
    stb.wdata  = wdata;
    stb.modeWr = ctrlWr && wdata[KIND_BIT];
    stb.bitWr  = ctrlWr && !wdata[KIND_BIT];
    stb.bitSel = wdata[SEL_W:1];
    stb.bitVal = wdata[0];
    stb.wrA    = wrHit && (addr == ADR_A);
    stb.wrB    = wrHit && (addr == ADR_B);
    stb.wrC    = wrHit && (addr == ADR_C);
    stb.rdA    = rdHit && (addr == ADR_A);
    stb.rdB    = rdHit && (addr == ADR_B);
    stb.rdEn   = rdHit;
    stb.rdAddr = addr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= CFG_RESET;
    end else if (stb.modeWr) begin
      cfg.aHs  <= wdata[A_HS_BIT];
      cfg.aIn  <= wdata[A_IN_BIT];
      cfg.cuIn <= wdata[CU_IN_BIT];
      cfg.bHs  <= wdata[B_HS_BIT];
      cfg.bIn  <= wdata[B_IN_BIT];
      cfg.clIn <= wdata[CL_IN_BIT];
    end
  end
endmodule

// File: rtl/pio_hs_port.sv
module pio_hs_port
  import pio_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             hsEn,
  input  logic             dirIn,
  input  logic [PIO_W-1:0] pinIn,
  input  logic             stbN,
  input  logic             wrStb,
  input  logic             rdStb,
  input  logic [PIO_W-1:0] wdata,
  input  logic             inte,
  output logic [PIO_W-1:0] latchOut,
  output logic [PIO_W-1:0] readVal,
  output logic             flagPin,
  output logic             intrPin
);
  logic [PIO_W-1:0] outQ, inQ;
  logic full, done;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ <= '0;
      inQ  <= '0;
      full <= 1'b0;
      done <= 1'b0;
    end else if (clr) begin
      outQ <= '0;
      inQ  <= '0;
      full <= 1'b0;
      done <= 1'b0;
    end else begin
      if (wrStb) outQ <= wdata;
      if (hsEn && dirIn) begin
        if (!stbN) begin
          inQ  <= pinIn;
          full <= 1'b1;
        end else if (rdStb) begin
          full <= 1'b0;
        end
      end else if (hsEn) begin
        if (wrStb) begin
          full <= 1'b1;
          done <= 1'b0;
        end else if (!stbN && full) begin
          full <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign latchOut = outQ;
  assign readVal  = dirIn ? (hsEn ? inQ : pinIn) : outQ;
  assign flagPin  = dirIn ? full : !full;
  assign intrPin  = inte && (dirIn ? full : done);
endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pioStrobe_t       stb,
  input  pioCfg_t          cfg,
  output logic [PIO_W-1:0] rdata,
  input  logic [PIO_W-1:0] paIn,
  output logic [PIO_W-1:0] paOut,
  output logic [PIO_W-1:0] paOe,
  input  logic [PIO_W-1:0] pbIn,
  output logic [PIO_W-1:0] pbOut,
  output logic [PIO_W-1:0] pbOe,
  input  logic [PIO_W-1:0] pcIn,
  output logic [PIO_W-1:0] pcOut,
  output logic [PIO_W-1:0] pcOe
);
  localparam int NPORT = 2;

  logic [PIO_W-1:0] pcLatch;
  logic [NPORT-1:0] hsEn, dirIn, halfIn, stbN, wrP, rdP, inte, flag, intr;
  logic [PIO_W-1:0] pinIn   [NPORT];
  logic [PIO_W-1:0] latchQ  [NPORT];
  logic [PIO_W-1:0] readV   [NPORT];
  logic [PIO_W-1:0] pcRead;

  // index 0 = group A (upper half of C), index 1 = group B (lower half)
  assign hsEn   = {cfg.bHs, cfg.aHs};
  assign dirIn  = {cfg.bIn, cfg.aIn};
  assign halfIn = {cfg.clIn, cfg.cuIn};
  assign stbN   = {pcIn[STB_OFS], pcIn[HALF_W+STB_OFS]};
  assign inte   = {pcLatch[INTE_OFS], pcLatch[HALF_W+INTE_OFS]};
  assign wrP    = {stb.wrB, stb.wrA};
  assign rdP    = {stb.rdB, stb.rdA};
  assign pinIn[0] = paIn;
  assign pinIn[1] = pbIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pcLatch <= '0;
    else if (stb.modeWr)  pcLatch <= '0;
    else if (stb.wrC)     pcLatch <= stb.wdata;
    else if (stb.bitWr)   pcLatch[stb.bitSel] <= stb.bitVal;
  end

  for (genvar g = 0; g < NPORT; g++) begin : genGrp
    localparam int BASE = (g == 0) ? HALF_W : 0;
    logic [HALF_W-1:0] hOut, hOe;

    pio_hs_port u_hs (
      .clk      (clk),
      .rstN     (rstN),
      .clr      (stb.modeWr),
      .hsEn     (hsEn[g]),
      .dirIn    (dirIn[g]),
      .pinIn    (pinIn[g]),
      .stbN     (stbN[g]),
      .wrStb    (wrP[g]),
      .rdStb    (rdP[g]),
      .wdata    (stb.wdata),
      .inte     (inte[g]),
      .latchOut (latchQ[g]),
      .readVal  (readV[g]),
      .flagPin  (flag[g]),
      .intrPin  (intr[g])
    );

    always_comb begin
      hOut = pcLatch[BASE +: HALF_W];
      hOe  = {HALF_W{!halfIn[g]}};
      if (hsEn[g]) begin
        hOut[FLAG_OFS] = flag[g];
        hOut[INTR_OFS] = intr[g];
        hOe            = '1;
        hOe[STB_OFS]   = 1'b0;
      end
    end
  end

  assign pcOut = {genGrp[0].hOut, genGrp[1].hOut};
  assign pcOe  = {genGrp[0].hOe,  genGrp[1].hOe};
  assign paOut = latchQ[0];
  assign pbOut = latchQ[1];
  assign paOe  = {PIO_W{!cfg.aIn}};
  assign pbOe  = {PIO_W{!cfg.bIn}};
  assign pcRead = (pcOe & pcOut) | (~pcOe & pcIn);

  always_comb begin
    rdata = '0;
    if (stb.rdEn) begin
      case (stb.rdAddr)
        ADR_A:   rdata = readV[0];
        ADR_B:   rdata = readV[1];
        ADR_C:   rdata = pcRead;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pio_three_port.sv
module pio_three_port
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIO_W-1:0]  wdata,
  output logic [PIO_W-1:0]  rdata,
  input  logic [PIO_W-1:0]  paIn,
  output logic [PIO_W-1:0]  paOut,
  output logic [PIO_W-1:0]  paOe,
  input  logic [PIO_W-1:0]  pbIn,
  output logic [PIO_W-1:0]  pbOut,
  output logic [PIO_W-1:0]  pbOe,
  input  logic [PIO_W-1:0]  pcIn,
  output logic [PIO_W-1:0]  pcOut,
  output logic [PIO_W-1:0]  pcOe
);
  pioStrobe_t stb;
  pioCfg_t    cfg;

  pio_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addr(addr), .wdata(wdata), .stb(stb), .cfg(cfg)
  );

  pio_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfg(cfg), .rdata(rdata),
    .paIn(paIn), .paOut(paOut), .paOe(paOe),
    .pbIn(pbIn), .pbOut(pbOut), .pbOe(pbOe),
    .pcIn(pcIn), .pcOut(pcOut), .pcOe(pcOe)
  );
endmodule

// File: rtl/pio_checker.sv
module pio_checker
  import pio_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rdN,
  input logic              wrN,
  input logic [ADDR_W-1:0] addr,
  input logic [PIO_W-1:0]  wdata,
  input logic [PIO_W-1:0]  rdata,
  input logic [PIO_W-1:0]  paOut,
  input logic [PIO_W-1:0]  paOe,
  input logic [PIO_W-1:0]  pbOut,
  input logic [PIO_W-1:0]  pbOe,
  input logic [PIO_W-1:0]  pcIn,
  input logic [PIO_W-1:0]  pcOut,
  input pioCfg_t           cfg
);
  logic busWr, cfgWr, bitWr;
  assign busWr = !csN && !wrN;
  assign cfgWr = busWr && addr == ADR_CTRL && wdata[KIND_BIT];
  assign bitWr = busWr && addr == ADR_CTRL && !wdata[KIND_BIT];

  // R2
  unselected_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> rdata == '0);

  // R7
  ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rdN && addr == ADR_CTRL) |-> rdata == '0);

  // R4
  cfg_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (paOut == '0 && pbOut == '0));

  // R5
  bit_word_local_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitWr |=> ($stable(paOut) && $stable(pbOut) && $stable(paOe) && $stable(pbOe)));

  // R8
  strobe_fills_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.aHs && cfg.aIn && !pcIn[HALF_W+STB_OFS] && !cfgWr) |=> pcOut[HALF_W+FLAG_OFS]);

  // R9
  write_sets_obf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.bHs && !cfg.bIn && busWr && addr == ADR_B) |=> !pcOut[FLAG_OFS]);

  // R9
  ack_frees_obf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.bHs && !cfg.bIn && !pcIn[STB_OFS] && !pcOut[FLAG_OFS] && !busWr) |=> pcOut[FLAG_OFS]);
endmodule

bind pio_three_port pio_checker u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
  .wdata(wdata), .rdata(rdata), .paOut(paOut), .paOe(paOe), .pbOut(pbOut),
  .pbOe(pbOe), .pcIn(pcIn), .pcOut(pcOut), .cfg(cfg)
);

// File: tb/pio_three_port_tb.sv
module pio_three_port_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] paIn = 8'h11, pbIn = 8'h22, pcIn = 8'h33;
  logic [7:0] paOut, paOe, pbOut, pbOe, pcOut, pcOe;
  int total = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pio_three_port u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
    .wdata(wdata), .rdata(rdata), .paIn(paIn), .paOut(paOut), .paOe(paOe),
    .pbIn(pbIn), .pbOut(pbOut), .pbOe(pbOe), .pcIn(pcIn), .pcOut(pcOut), .pcOe(pcOe)
  );

  // {op, addr, data, expect}: op 1 = write, 2 = read and compare
  localparam int NV = 22;
  localparam logic [19:0] VEC [NV] = '{
    {2'd1, 2'd3, 8'h80, 8'h00},  // R3 all outputs, basic
    {2'd1, 2'd0, 8'h5A, 8'h00},
    {2'd2, 2'd0, 8'h00, 8'h5A},  // R6
    {2'd1, 2'd1, 8'hC3, 8'h00},
    {2'd2, 2'd1, 8'h00, 8'hC3},  // R6
    {2'd1, 2'd2, 8'h96, 8'h00},
    {2'd2, 2'd2, 8'h00, 8'h96},  // R12
    {2'd1, 2'd3, 8'h01, 8'h00},  // R5 set bit 0
    {2'd2, 2'd2, 8'h00, 8'h97},
    {2'd1, 2'd3, 8'h7E, 8'h00},  // R5 clear bit 7, junk in 6:4
    {2'd2, 2'd2, 8'h00, 8'h17},
    {2'd2, 2'd3, 8'h00, 8'h00},  // R7
    {2'd2, 2'd0, 8'h00, 8'h5A},  // R5 port A untouched
    {2'd1, 2'd3, 8'hB6, 8'h00},  // R3 all inputs
    {2'd2, 2'd0, 8'h00, 8'h11},  // R6
    {2'd2, 2'd1, 8'h00, 8'h22},
    {2'd2, 2'd2, 8'h00, 8'h33},  // R12
    {2'd1, 2'd3, 8'h80, 8'h00},
    {2'd2, 2'd0, 8'h00, 8'h00},  // R4
    {2'd2, 2'd2, 8'h00, 8'h00},  // R4
    {2'd1, 2'd3, 8'h90, 8'h00},  // R3 upper C input
    {2'd2, 2'd2, 8'h00, 8'h30}   // R12
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; wrN = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic pulseC(input int bitIdx);
    @(negedge clk);
    pcIn[bitIdx] = 1'b0;
    @(negedge clk);
    pcIn[bitIdx] = 1'b1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 paOe", paOe, 8'h00);
    chk("R1 pcOe", pcOe, 8'h00);
    chk("R1 paOut", paOut, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R2 deselected write has no effect
    @(negedge clk);
    csN = 1'b1; wrN = 1'b0; addr = 2'd3; wdata = 8'h80;
    @(negedge clk);
    wrN = 1'b1;
    chk("R2 paOe", paOe, 8'h00);
    rdN = 1'b0; addr = 2'd0;
    #1 chk("R2 rdata", rdata, 8'h00);
    rdN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19:18] == 2'd1) busWrite(VEC[i][17:16], VEC[i][15:8]);
      else begin
        busRead(VEC[i][17:16], rd);
        chk($sformatf("R3/R4/R5/R6/R7/R12 vector %0d", i), rd, VEC[i][7:0]);
      end
      if (i == 0) begin
        chk("R3 paOe out", paOe, 8'hFF);
        chk("R6 paOut", paOut, 8'h00);
      end
      if (i == 13) chk("R3 pbOe in", pbOe, 8'h00);
    end

    // R8 handshake input on port A
    busWrite(2'd3, 8'hE0);
    chk("R11 pcOe", pcOe, 8'hEF);
    chk("R3 pbOe", pbOe, 8'hFF);
    busWrite(2'd3, 8'h0F);
    paIn = 8'hA5;
    pulseC(4);
    paIn = 8'h00;
    @(negedge clk);
    chk("R8 ibf set", {7'd0, pcOut[5]}, 8'h01);
    chk("R10 intr A", {7'd0, pcOut[6]}, 8'h01);
    busRead(2'd0, rd);
    chk("R8 latched read", rd, 8'hA5);
    chk("R8 ibf clear", {7'd0, pcOut[5]}, 8'h00);
    chk("R10 intr A clear", {7'd0, pcOut[6]}, 8'h00);
    busWrite(2'd3, 8'h0E);
    pulseC(4);
    @(negedge clk);
    chk("R8 ibf again", {7'd0, pcOut[5]}, 8'h01);
    chk("R10 intr masked", {7'd0, pcOut[6]}, 8'h00);
    busWrite(2'd3, 8'hE0);
    chk("R4 ibf cleared", {7'd0, pcOut[5]}, 8'h00);

    // R9 handshake output on port B
    busWrite(2'd3, 8'h88);
    chk("R11 pcOe B", pcOe, 8'hFE);
    chk("R9 obf idle", {7'd0, pcOut[1]}, 8'h01);
    busWrite(2'd3, 8'h07);
    busWrite(2'd1, 8'h3C);
    chk("R9 pbOut", pbOut, 8'h3C);
    chk("R9 obf low", {7'd0, pcOut[1]}, 8'h00);
    chk("R10 intr B idle", {7'd0, pcOut[2]}, 8'h00);
    pulseC(0);
    @(negedge clk);
    chk("R9 obf released", {7'd0, pcOut[1]}, 8'h01);
    chk("R10 intr B", {7'd0, pcOut[2]}, 8'h01);
    busWrite(2'd1, 8'h55);
    chk("R10 intr B clear", {7'd0, pcOut[2]}, 8'h00);
    chk("R9 obf low again", {7'd0, pcOut[1]}, 8'h00);

    finish();
  end
endmodule